// File: doc/BRIEF.md
# Predistortion Look-Up Address Generator

This block turns a stream of complex baseband samples into read addresses for a gain-correction table. Each cycle it may accept one signed I/Q pair with a valid strobe. It forms the squared envelope I² + Q², scales it by a programmable fixed-point gain and clips it to a 6-bit level index. Levels below a programmable envelope threshold collapse to level 0, the linear-gain entry. Levels above the top of the range stick at 63 and never wrap.

A one-entry history holds the level of the previous valid sample. In two-dimensional mode the address is the current level plus 64 times the previous level. In one-dimensional mode it is the current level alone. The address comes out four clocks after its sample, with a valid flag and with the I/Q pair delayed to match, so the table read and the complex multiply that follow can line up without extra work.

Gain, threshold and mode are taken into an internal copy only on cycles when no sample is in flight. A sample therefore always sees one consistent setting.

Top module: `lutaddr_gen`

## Requirements
- R1: The envelope is P = I² + Q², with I and Q read as 16-bit two's-complement values. The full range is exact, up to P = 2^31.
- R2: The level is floor(P × G / 2^24), where G is the unsigned gain with 8 fractional bits. With G = 256 the level is floor(P / 65536).
- R3: A level above 63 is output as 63 and never wraps.
- R4: When P is below the threshold (compared with the raw envelope P), the level is 0, whatever the gain.
- R5: With mode = 1 (two-dimensional), the address is cur + 64 × prev, where prev is the level of the previous valid sample. Bits [5:0] hold cur and bits [11:6] hold prev.
- R6: The history advances only on cycles with in_valid high. Idle cycles between two samples do not change which level is used as prev.
- R7: With mode = 0 (one-dimensional), the address equals cur and bits [11:6] are zero.
- R8: out_valid follows in_valid exactly 4 clocks later, and back-to-back samples give back-to-back addresses.
- R9: out_i and out_q equal the in_i and in_q sampled with the same valid strobe, on the same cycle as the address.
- R10: Reset clears out_valid and out_addr and empties the history, so the first sample after reset uses prev = 0.
- R11: Changes to gain, threshold or mode made while any sample is in flight do not affect that sample. They take effect once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| cfg_gain | input | 16 | Envelope gain, unsigned, 8 fractional bits |
| cfg_thresh | input | 32 | Envelope threshold below which the level is 0 |
| cfg_mode | input | 1 | 1: two-dimensional address, 0: one-dimensional |
| out_valid | output | 1 | Address valid |
| out_addr | output | 12 | Table address |
| out_i | output | 16 | I aligned with the address |
| out_q | output | 16 | Q aligned with the address |

## Verification
Every address, its valid flag and its aligned I/Q are due at the fourth rising edge after the edge that captured the sample. The bench drives on falling edges and records the expected address and I/Q for each sample in the order the samples are sent. A monitor then compares each out_valid cycle, at the falling edge, with the next recorded entry. This catches any sample that is dropped, duplicated or shifted. A directed test also counts falling edges from the drive to the first out_valid and expects exactly four. Configuration changes are sent together with samples already in flight, so the cycle in which a new setting takes effect is checked as well.

// File: rtl/lutaddr_pkg.sv
package lutaddr_pkg;
  typedef enum logic {
    MODE_1D = 1'b0,
    MODE_2D = 1'b1
  } addr_mode_e;

  localparam int unsigned PIPE_LAT = 4;
endpackage

// File: rtl/lutaddr_env_stage.sv
module lutaddr_env_stage #(
  parameter int IQ_W = 16,
  localparam int PW  = 2 * IQ_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   v_i,
  input  logic signed [IQ_W-1:0] i_i,
  input  logic signed [IQ_W-1:0] q_i,
  output logic                   v_o,
  output logic [PW-1:0]          pow_o
);
  logic signed [PW-1:0] ie, qe;
  logic [PW-1:0] sq_i, sq_q, pow_nxt;

  always_comb begin
    ie      = PW'(i_i);
    qe      = PW'(q_i);
    sq_i    = ie * ie;
    sq_q    = qe * qe;
    pow_nxt = sq_i + sq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      pow_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) pow_o <= pow_nxt;
    end
  end

  // R1: envelope never exceeds 2 * (2^(IQ_W-1))^2
  assert_env_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (pow_o <= (PW'(1) << (PW-1))));
endmodule

// File: rtl/lutaddr_quant_stage.sv
module lutaddr_quant_stage #(
  parameter int PW        = 32,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int IDX_W     = 6,
  parameter int IDX_LSB   = 16,
  localparam int PROD_W   = PW + GAIN_W,
  localparam int SH       = GAIN_FRAC + IDX_LSB,
  localparam int IDX_MAX  = (1 << IDX_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  logic [PW-1:0]     pow_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [PW-1:0]     thr_i,
  output logic              v_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [PROD_W-1:0] prod, lvl;
  logic [IDX_W-1:0]  idx_nxt;

  always_comb begin
    prod = PROD_W'(pow_i) * PROD_W'(gain_i);
    lvl  = prod >> SH;
    if (pow_i < thr_i)
      idx_nxt = '0;
    else if (lvl > PROD_W'(IDX_MAX))
      idx_nxt = IDX_W'(IDX_MAX);
    else
      idx_nxt = lvl[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      idx_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) idx_o <= idx_nxt;
    end
  end

  assert_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && pow_i < thr_i) |=> (idx_o == '0));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && pow_i >= thr_i && (prod >> SH) > PROD_W'(IDX_MAX)) |=> (idx_o == IDX_W'(IDX_MAX)));
endmodule

// File: rtl/lutaddr_assemble.sv
module lutaddr_assemble #(
  parameter int IDX_W    = 6,
  localparam int ADDR_W  = 2 * IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  lutaddr_pkg::addr_mode_e  mode_i,
  output logic                     v_o,
  output logic [ADDR_W-1:0]        addr_o
);
  import lutaddr_pkg::*;

  logic [IDX_W-1:0]  hist_q, cur_q, prev_q;
  logic              v3_q;
  logic [ADDR_W-1:0] addr_nxt;

  // stage 3: history tap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
      v3_q   <= 1'b0;
    end else begin
      v3_q <= v_i;
      if (v_i) begin
        cur_q  <= idx_i;
        prev_q <= hist_q;
        hist_q <= idx_i;
      end
    end
  end

  // cur + 2^IDX_W * prev is a plain concatenation
  always_comb begin
    if (mode_i == MODE_2D) addr_nxt = {prev_q, cur_q};
    else                   addr_nxt = {{IDX_W{1'b0}}, cur_q};
  end

  // stage 4: address register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      addr_o <= '0;
    end else begin
      v_o <= v3_q;
      if (v3_q) addr_o <= addr_nxt;
    end
  end

  assert_hist_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> (hist_q == $past(idx_i)));

  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> $stable(hist_q));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_o && mode_i == MODE_1D) |-> (addr_o[ADDR_W-1:IDX_W] == '0));
endmodule

// File: rtl/lutaddr_gen.sv
module lutaddr_gen #(
  parameter int IQ_W      = 16,
  parameter int IDX_W     = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8,
  parameter int IDX_LSB   = 16,
  localparam int PW       = 2 * IQ_W,
  localparam int ADDR_W   = 2 * IDX_W,
  localparam int LAT      = lutaddr_pkg::PIPE_LAT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IQ_W-1:0] in_i,
  input  logic signed [IQ_W-1:0] in_q,
  input  logic [GAIN_W-1:0]      cfg_gain,
  input  logic [PW-1:0]          cfg_thresh,
  input  logic                   cfg_mode,
  output logic                   out_valid,
  output logic [ADDR_W-1:0]      out_addr,
  output logic signed [IQ_W-1:0] out_i,
  output logic signed [IQ_W-1:0] out_q
);
  import lutaddr_pkg::*;

  // configuration copy, loaded only when nothing is in flight
  logic [GAIN_W-1:0] gain_q;
  logic [PW-1:0]     thr_q;
  addr_mode_e        mode_q;
  logic              busy;

  logic [LAT-1:0]    vq;
  logic [IQ_W-1:0]   di [LAT];
  logic [IQ_W-1:0]   dq [LAT];

  always_comb busy = in_valid | vq[0] | vq[1] | vq[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      thr_q  <= '0;
      mode_q <= MODE_1D;
    end else if (!busy) begin
      gain_q <= cfg_gain;
      thr_q  <= cfg_thresh;
      mode_q <= addr_mode_e'(cfg_mode);
    end
  end

  // I/Q alignment delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vq <= '0;
    else        vq <= {vq[LAT-2:0], in_valid};
  end

  generate
    for (genvar k = 0; k < LAT; k++) begin : g_iq_dly
      logic           en;
      logic [IQ_W-1:0] src_i, src_q;
      if (k == 0) begin : g_head
        always_comb begin
          en    = in_valid;
          src_i = in_i;
          src_q = in_q;
        end
      end else begin : g_body
        always_comb begin
          en    = vq[k-1];
          src_i = di[k-1];
          src_q = dq[k-1];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          di[k] <= '0;
          dq[k] <= '0;
        end else if (en) begin
          di[k] <= src_i;
          dq[k] <= src_q;
        end
      end
    end
  endgenerate

  logic              v1, v2;
  logic [PW-1:0]     pow1;
  logic [IDX_W-1:0]  idx2;

  lutaddr_env_stage #(.IQ_W(IQ_W)) u_env (
    .clk, .rst_n, .v_i(in_valid), .i_i(in_i), .q_i(in_q),
    .v_o(v1), .pow_o(pow1)
  );

  lutaddr_quant_stage #(
    .PW(PW), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
    .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)
  ) u_quant (
    .clk, .rst_n, .v_i(v1), .pow_i(pow1), .gain_i(gain_q), .thr_i(thr_q),
    .v_o(v2), .idx_o(idx2)
  );

  lutaddr_assemble #(.IDX_W(IDX_W)) u_asm (
    .clk, .rst_n, .v_i(v2), .idx_i(idx2), .mode_i(mode_q),
    .v_o(out_valid), .addr_o(out_addr)
  );

  always_comb begin
    out_i = di[LAT-1];
    out_q = dq[LAT-1];
  end

  // cycles since reset, saturating at the latency
  logic [2:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (cyc_q != 3'd4) cyc_q <= cyc_q + 3'd1;
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vq[LAT-1]);

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(gain_q) && $stable(thr_q) && $stable(mode_q)));
endmodule

// File: tb/tb_lutaddr_gen.sv
module tb_lutaddr_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] in_i, in_q;
  logic [15:0] cfg_gain;
  logic [31:0] cfg_thresh;
  logic cfg_mode;
  logic out_valid;
  logic [11:0] out_addr;
  logic signed [15:0] out_i, out_q;

  always #2 clk = ~clk; // 250 MHz

  lutaddr_gen dut (
    .clk, .rst_n, .in_valid, .in_i, .in_q, .cfg_gain, .cfg_thresh,
    .cfg_mode, .out_valid, .out_addr, .out_i, .out_q
  );

  int n_chk = 0;
  int n_bad = 0;

  // stimulus table: I, Q, expected level at gain 256, threshold 0
  localparam int NV = 10;
  localparam int TV_I [NV] = '{0, 256, 0,    1000, -1448, 2048, -32768, 512, 724, -1};
  localparam int TV_Q [NV] = '{0, 0,   -256, 1000, 1448,  0,    -32768, 512, 0,   0};
  localparam int TV_X [NV] = '{0, 1,   1,    30,   63,    63,   63,     8,   7,   0};

  // expected-output queue
  int    exp_addr [512];
  int    exp_i    [512];
  int    exp_q    [512];
  string exp_tag  [512];
  int wr = 0, rd = 0;

  // bench model state
  int  prev_m = 0;
  int  eff_gain = 256;
  longint eff_thr = 0;
  bit  eff_2d = 1'b1;

  task automatic chk(string req, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model_idx(int i, int q);
    longint p, s;
    p = longint'(i) * i + longint'(q) * q;
    if (p < eff_thr) return 0;
    s = (p * eff_gain) >>> 24;
    if (s > 63) return 63;
    return int'(s);
  endfunction

  task automatic send(int i, int q, int xidx, string tag);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    exp_addr[wr] = eff_2d ? (xidx + 64 * prev_m) : xidx;
    exp_i[wr] = int'(16'(i));
    exp_q[wr] = int'(16'(q));
    exp_tag[wr] = tag;
    wr++;
    prev_m = xidx;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        chk("R8 unexpected out_valid", 1, 0);
      end else begin
        chk(exp_tag[rd], out_addr, exp_addr[rd]);
        chk("R9 out_i", out_i, exp_i[rd]);
        chk("R9 out_q", out_q, exp_q[rd]);
        rd++;
      end
    end
  end

  task automatic run_all();
    int lat;
    int x;
    // R10: reset state
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    cfg_gain = 16'd256; cfg_thresh = '0; cfg_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", out_valid, 0);
    chk("R10 out_addr in reset", out_addr, 0);
    rst_n = 1'b1;
    idle(2);

    // table walk, back to back, 2D mode: R1 R2 R3 R5; first uses prev 0 (R10)
    for (int k = 0; k < NV; k++) begin
      x = model_idx(TV_I[k], TV_Q[k]);
      chk("R2 model vs table", x, TV_X[k]);
      send(TV_I[k], TV_Q[k], TV_X[k], "R5 addr 2D");
    end
    idle(6);

    // R8: latency of an isolated sample
    send(1000, 1000, 30, "R8 addr");
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
    chk("R8 latency", lat, 4);
    idle(4);

    // R6: idle gaps do not advance history
    send(512, 512, 8, "R6 addr");
    idle(3);
    send(256, 0, 1, "R6 addr after gap");
    idle(6);

    // R4: threshold above 524288 forces level 0
    cfg_thresh = 32'd600000; idle(2); eff_thr = 600000;
    send(512, 512, 0, "R4 below thr");
    send(1000, 1000, 30, "R4 above thr");
    send(-32768, 0, 63, "R3 sat");
    idle(6);
    cfg_thresh = '0; idle(2); eff_thr = 0;

    // R2: gain 512 doubles the level
    cfg_gain = 16'd512; idle(2); eff_gain = 512;
    send(512, 512, 16, "R2 gain 512");
    send(256, 256, 4, "R2 gain 512");
    idle(6);

    // R11: gain changed while samples are in flight
    eff_gain = 256;
    cfg_gain = 16'd256; idle(2);
    cfg_gain = 16'd1024;
    send(1000, 1000, 30, "R11 old gain");
    send(512, 512, 8, "R11 old gain");
    idle(6); eff_gain = 1024;
    send(256, 0, 4, "R11 new gain");
    idle(6);
    cfg_gain = 16'd256; idle(2); eff_gain = 256;

    // R7: one-dimensional mode
    cfg_mode = 1'b0; idle(2); eff_2d = 1'b0;
    send(2048, 0, 63, "R7 addr 1D");
    send(1000, 1000, 30, "R7 addr 1D");
    idle(6);
    cfg_mode = 1'b1; idle(2); eff_2d = 1'b1;

    // R10: mid-run reset clears history
    send(-1448, 1448, 63, "R5 before reset");
    idle(6);
    rst_n = 1'b0; @(negedge clk);
    chk("R10 out_valid after reset", out_valid, 0);
    chk("R10 out_addr after reset", out_addr, 0);
    rst_n = 1'b1; prev_m = 0;
    idle(3);
    send(512, 512, 8, "R10 prev cleared");
    idle(8);
    chk("R8 all outputs seen", rd, wr);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule